// File: doc/BRIEF.md
# Interrupt Cause/Mask Aggregator with Summary Bits

This block collects up to 29 peripheral interrupt requests into one 32-bit cause word. Each request line sets a sticky cause bit. Software clears a bit by writing a zero into its position; writing a one leaves the bit as it is. A mask word selects which pending causes may reach the CPU. The block drives a single interrupt line and the index of the lowest-numbered pending source that the mask lets through.

Three positions of the cause word are not storage. They are read-only summaries of the unmasked cause bits: one OR over every source, and two ORs over fixed source groups. A CPU-side "interrupt taken" strobe is checked against the pending state. If no masked-in source was pending when the strobe arrived, a one-cycle spurious flag is raised.

Access goes through a plain synchronous register port. It has a one-bit word address, a write enable, a read enable and 32-bit data. Every access completes in one cycle, so the port has no back-pressure and no valid/ready handshake. Read data is registered.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the cause and mask registers are zero, and cpu_irq_o, pend_idx_o, spurious_o and bus_rdata_o are all zero.
- R2: When src_i[j] is high at a clock edge, cause bit j+1 is one after that edge. The bit stays set until software clears it.
- R3: A write to address 0 (cause) clears every cause bit in positions 1 to 29 whose write-data bit is 0. Bits whose write-data bit is 1 keep their value. If the source of a bit is high in the same cycle as the clearing write, the bit stays set.
- R4: A write to address 1 (mask) stores write-data bits 29 to 1 as the mask. Mask read-back shows bits 0, 30 and 31 as zero.
- R5: Cause read-back bit 0 is the OR of cause bits 29 to 1.
- R6: Cause read-back bit 30 is the OR of cause bits 29 to 26 and 20 to 1.
- R7: Cause read-back bit 31 is the OR of cause bits 25 to 1.
- R8: The summary bits ignore the mask. Writes to cause bits 0, 30 and 31 have no effect.
- R9: cpu_irq_o is high exactly when some cause bit in 1 to 29 is set and its mask bit is also set.
- R10: pend_idx_o gives the lowest bit number in 1 to 29 that is both pending and masked in. It is 0 when there is none.
- R11: If irq_take_i is high in a cycle, spurious_o is high in the next cycle exactly when no masked-in source was pending in the cycle of the strobe. Otherwise spurious_o is low.
- R12: When bus_re_i is high at an edge, bus_rdata_o shows the word at bus_addr_i as it was before that edge. Without a read, bus_rdata_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 29 | Source requests; bit j feeds cause bit j+1 |
| bus_addr_i | input | 1 | Word select: 0 cause, 1 mask |
| bus_we_i | input | 1 | Write enable |
| bus_wdata_i | input | 32 | Write data |
| bus_re_i | input | 1 | Read enable |
| bus_rdata_o | output | 32 | Registered read data |
| irq_take_i | input | 1 | Strobe from the CPU when it takes the interrupt |
| cpu_irq_o | output | 1 | Interrupt line to the CPU |
| pend_idx_o | output | 5 | Lowest masked-in pending source number, 0 if none |
| spurious_o | output | 1 | Strobe taken with nothing pending |

## Verification
The assertions run on every cycle. They check that a high source is always captured, and that cause bits never fall except during a clearing write. They also check that the encoded index points at the lowest pending, masked-in bit and agrees with the interrupt line, and that a spurious flag only follows a strobe taken while the line was low. Some behaviours need the bench's scenarios to show them. These are the exact summary group boundaries at bits 20/21 and 25/26, the set-over-clear race, the mask-independence of the summaries, the ignored summary writes and the read-data hold.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_SRC  = 29;
  localparam int unsigned IDX_W    = $clog2(NUM_SRC + 1);
  localparam int unsigned ALL_POS  = 0;
  localparam int unsigned GA_POS   = 30;
  localparam int unsigned GB_POS   = 31;
  // group membership over cause positions (bit k = cause bit k)
  localparam logic [WORD_W-1:0] GRP_A = 32'h3C1F_FFFE; // 29:26 and 20:1
  localparam logic [WORD_W-1:0] GRP_B = 32'h03FF_FFFE; // 25:1

  typedef enum logic {
    ADDR_CAUSE = 1'b0,
    ADDR_MASK  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import irq_agg_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] clr_keep_i,
  output logic [N-1:0] cause_o
);
  logic [N-1:0] cause_q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        cause_q[k] <= 1'b0;
      else if (src_i[k])
        cause_q[k] <= 1'b1;
      else if (clr_en_i && !clr_keep_i[k])
        cause_q[k] <= 1'b0;
    end
  end

  assign cause_o = cause_q;

  // R2: every high source is captured
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i != '0) |=> ((cause_q & $past(src_i)) == $past(src_i)));

  // R3: bits only fall during a clearing write
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en_i |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_agg_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic [N-1:0]      cause_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] pos;
  logic              grp_a, grp_b;

  always_comb begin
    pos = '0;
    pos[N:1] = cause_i;
  end

  assign grp_a = |(pos & GRP_A);
  assign grp_b = |(pos & GRP_B);

  always_comb begin
    word_o          = pos;
    word_o[ALL_POS] = |cause_i;
    word_o[GA_POS]  = grp_a;
    word_o[GB_POS]  = grp_b;
  end
endmodule

// File: rtl/irq_low_enc.sv
module irq_low_enc
  import irq_agg_pkg::*;
#(
  parameter int unsigned N = NUM_SRC,
  parameter int unsigned W = IDX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (pend_i[k]) idx_o = W'(k + 1);
    end
  end

  assign any_o = |pend_i;

  // R10: index marks a pending bit with nothing pending below it
  a_r10_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_o != '0) |-> (pend_i[idx_o - 1'b1] &&
      ((pend_i & ((N'(1) << (idx_o - 1'b1)) - N'(1))) == '0)));

  a_r10_none: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_o == '0) |-> (pend_i == '0));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic              bus_addr_i,
  input  logic              bus_we_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  input  logic              bus_re_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  input  logic              irq_take_i,
  output logic              cpu_irq_o,
  output logic [IDX_W-1:0]  pend_idx_o,
  output logic              spurious_o
);
  logic [NUM_SRC-1:0] cause, mask_q, pend;
  logic [WORD_W-1:0]  cause_word, mask_word, rdata_q;
  logic               clr_en, mask_we, any_pend, spur_q;

  assign clr_en  = bus_we_i && (reg_sel_e'(bus_addr_i) == ADDR_CAUSE);
  assign mask_we = bus_we_i && (reg_sel_e'(bus_addr_i) == ADDR_MASK);

  irq_cause_bank #(.N(NUM_SRC)) u_cause (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .clr_en_i(clr_en), .clr_keep_i(bus_wdata_i[NUM_SRC:1]),
    .cause_o(cause)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= bus_wdata_i[NUM_SRC:1];
  end

  irq_summary #(.N(NUM_SRC)) u_sum (.cause_i(cause), .word_o(cause_word));

  always_comb begin
    mask_word = '0;
    mask_word[NUM_SRC:1] = mask_q;
  end

  assign pend = cause & mask_q;

  irq_low_enc #(.N(NUM_SRC), .W(IDX_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .pend_i(pend),
    .idx_o(pend_idx_o), .any_o(any_pend)
  );

  assign cpu_irq_o = any_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      spur_q  <= 1'b0;
    end else begin
      if (bus_re_i)
        rdata_q <= (reg_sel_e'(bus_addr_i) == ADDR_MASK) ? mask_word : cause_word;
      spur_q <= irq_take_i && !any_pend;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign spurious_o  = spur_q;

  // R9: line and index agree
  a_r9_line_idx: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_o == (pend_idx_o != '0));

  // R11: spurious only after a strobe taken with the line low
  a_r11_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_i && !cpu_irq_o |=> spurious_o);

  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_take_i && !cpu_irq_o) |=> !spurious_o);

  // R4: mask read-back never shows the reserved positions
  a_r4_mask_rsv: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_re_i) && $past(bus_addr_i) |->
      (bus_rdata_o[0] == 1'b0 && bus_rdata_o[31:30] == 2'b00));
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  import irq_agg_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_SRC-1:0] src = '0;
  logic addr = 1'b0, we = 1'b0, re = 1'b0, take = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic cpu_irq, spur;
  logic [IDX_W-1:0] idx;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_re_i(re),
    .bus_rdata_o(rdata), .irq_take_i(take), .cpu_irq_o(cpu_irq),
    .pend_idx_o(idx), .spurious_o(spur)
  );

  typedef struct packed {
    logic [31:0] cause_bits;  // positions 1..29 raised
    logic [31:0] mask_bits;
    logic        exp_irq;
    logic [4:0]  exp_idx;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0002, 32'h3FFF_FFFE, 1'b1, 5'd1},
    '{32'h2000_0000, 32'h2000_0000, 1'b1, 5'd29},
    '{32'h0240_0000, 32'h3FFF_FFFE, 1'b1, 5'd22},
    '{32'h0000_0408, 32'h0000_0400, 1'b1, 5'd10},
    '{32'h0000_0020, 32'h0000_0000, 1'b0, 5'd0},
    '{32'h0020_0000, 32'h0020_0000, 1'b1, 5'd21},
    '{32'h0400_0000, 32'h3FFF_FFFE, 1'b1, 5'd26}
  };

  function automatic logic [31:0] exp_word(input logic [31:0] b);
    logic [31:0] c;
    c = b & 32'h3FFF_FFFE;
    exp_word = c;
    exp_word[0]  = |c;                                  // R5
    exp_word[30] = (|c[29:26]) | (|c[20:1]);            // R6
    exp_word[31] = |c[25:1];                            // R7
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic pulse_src(input logic [31:0] b);
    @(negedge clk); src = b[29:1];
    @(negedge clk); src = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, cpu_irq}, 32'd0);
    chk("R1 idx", {27'd0, idx}, 32'd0);
    chk("R1 spur", {31'd0, spur}, 32'd0);
    chk("R1 rdata", rdata, 32'd0);
    rst_n = 1'b1;
    rd(1'b0, d); chk("R1 cause", d, 32'd0);
    rd(1'b1, d); chk("R1 mask", d, 32'd0);

    // table walk: R2 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      wr(1'b0, 32'h0);
      wr(1'b1, VECS[i].mask_bits);
      pulse_src(VECS[i].cause_bits);
      @(negedge clk);
      chk("R9 irq", {31'd0, cpu_irq}, {31'd0, VECS[i].exp_irq});
      chk("R10 idx", {27'd0, idx}, {27'd0, VECS[i].exp_idx});
      rd(1'b0, d); chk("R2/R5/R6/R7 cause word", d, exp_word(VECS[i].cause_bits));
      rd(1'b1, d); chk("R4 mask word", d, VECS[i].mask_bits & 32'h3FFF_FFFE);
    end

    // R4 reserved mask bits read zero
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, d); chk("R4 mask rsv", d, 32'h3FFF_FFFE);

    // R3 writing ones keeps, zeros clear
    wr(1'b0, 32'h0);
    pulse_src(32'h0000_0006);
    wr(1'b0, 32'hFFFF_FFFB);  // clear bit 2, keep bit 1
    rd(1'b0, d); chk("R3 partial clear", d, exp_word(32'h0000_0002));

    // R3 set wins over same-cycle clear
    @(negedge clk); src = 29'd1 << 3; addr = 1'b0; wdata = 32'h0; we = 1'b1;
    @(negedge clk); src = '0; we = 1'b0;
    rd(1'b0, d); chk("R3 set wins", d, exp_word(32'h0000_0010));

    // R8 writes to summary positions ignored; summaries ignore mask
    wr(1'b0, 32'h0);
    pulse_src(32'h0000_0004);
    wr(1'b1, 32'h0);
    wr(1'b0, 32'h0000_0004);
    rd(1'b0, d); chk("R8 summary ignore", d, 32'hC000_0005);
    chk("R8 masked irq low", {31'd0, cpu_irq}, 32'd0);

    // R11 spurious strobe
    @(negedge clk); take = 1'b1;
    @(negedge clk); take = 1'b0;
    chk("R11 spurious", {31'd0, spur}, 32'd1);
    @(negedge clk);
    chk("R11 one cycle", {31'd0, spur}, 32'd0);
    wr(1'b1, 32'h0000_0004);
    @(negedge clk); take = 1'b1;
    @(negedge clk); take = 1'b0;
    chk("R11 genuine", {31'd0, spur}, 32'd0);
    chk("R10 idx 2", {27'd0, idx}, 32'd2);

    // R12 read data holds without re
    rd(1'b0, held);
    pulse_src(32'h2000_0000);
    @(negedge clk);
    chk("R12 hold", rdata, held);
    rd(1'b0, d); chk("R12 refresh", d, exp_word(32'h2000_0004));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule